// File: doc/BRIEF.md
# Bit-Manipulation and Pack ALU Slice

This block is one execution slice of an integer pipeline. It handles the two-operand bit-manipulation group: the negated logic functions, the lane-packing functions, signed and unsigned minimum and maximum, byte and halfword sign extension, and the single-bit set, clear, invert and extract functions. A five-bit operation code selects the function. The operands are `rs1` and `rs2`, each `XLEN` bits wide (64 by default).

An operation is issued by raising `inValid` for one cycle. The result and the `illegalOp` flag are registered. They appear on the next clock edge with `outValid` high, and they hold their value until the next issue.

The single-bit functions take their bit index either from `rs2` or from the immediate field, as chosen by `useImm`. Only the low log2(XLEN) bits of that source are used.

Top module: `bitmanip_pack_alu`

## Requirements
- R1: Code 0 returns rs1 & ~rs2, code 1 returns rs1 | ~rs2, and code 2 returns ~(rs1 ^ rs2).
- R2: Code 3 returns rs1's low half in the low half of the result and rs2's low half in the upper half.
- R3: Code 4 returns rs1's upper half in the low half of the result and rs2's upper half in the upper half.
- R4: Code 5 returns rs1[7:0] in bits 7:0 and rs2[7:0] in bits 15:8. All bits above 15 are zero.
- R5: Code 6 forms the 32-bit value {rs2[15:0], rs1[15:0]} and code 7 forms {rs2[31:16], rs1[31:16]}. Each is sign-extended from bit 31 to XLEN. With XLEN = 32 both codes are illegal.
- R6: Code 8 returns the signed minimum of rs1 and rs2, and code 9 returns the signed maximum.
- R7: Code 10 returns the unsigned minimum, and code 11 returns the unsigned maximum.
- R8: Code 12 sign-extends rs1 from bit 7, and code 13 sign-extends rs1 from bit 15.
- R9: Codes 14, 15 and 16 each combine rs1 with the one-hot mask (1 << index): code 14 ORs it in, code 15 clears it (AND-NOT), and code 16 XORs it.
- R10: Code 17 returns (rs1 >> index) & 1.
- R11: The index is taken from `imm` when `useImm` is 1 and from `rs2` otherwise. Only its low log2(XLEN) bits are used.
- R12: A result issued with `inValid` appears one clock later with `outValid` high. In a cycle without `inValid`, `outValid` falls the next clock and `result` keeps its value.
- R13: Codes 18 to 31 set `illegalOp` and return zero. Legal codes clear `illegalOp`.
- R14: During reset, `outValid`, `illegalOp` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Issue strobe |
| opSel | input | 5 | Operation code |
| useImm | input | 1 | 1: bit index from imm, 0: from rs2 |
| imm | input | IMM_W (12) | Immediate field |
| rs1 | input | XLEN (64) | First operand |
| rs2 | input | XLEN (64) | Second operand |
| outValid | output | 1 | Result valid, one cycle after issue |
| result | output | XLEN (64) | Registered result |
| illegalOp | output | 1 | Unsupported operation code |

## Verification
The hardest cases to reach by chance are sign and magnitude boundaries. A signed comparison differs from an unsigned one only when the operands' top bits differ. A word pack sign-extends only when bit 15 of rs2 (code 6) or bit 31 of rs2 (code 7) is set. Uniformly random operands rarely land on equal operands or on index 63. The stimulus therefore draws each operand from a mix of uniform values and corner values (zero, all ones, most-negative, most-positive, single-bit). It draws immediates whose upper bits are set, so that the index truncation is exercised. Directed cases cover equal operands and the top index.

// File: rtl/bmpa_pkg.sv
package bmpa_pkg;
  localparam int OP_W = 5;

  localparam logic [OP_W-1:0] OP_ANDN   = 5'd0;
  localparam logic [OP_W-1:0] OP_ORN    = 5'd1;
  localparam logic [OP_W-1:0] OP_XNOR   = 5'd2;
  localparam logic [OP_W-1:0] OP_PACK   = 5'd3;
  localparam logic [OP_W-1:0] OP_PACKU  = 5'd4;
  localparam logic [OP_W-1:0] OP_PACKH  = 5'd5;
  localparam logic [OP_W-1:0] OP_PACKW  = 5'd6;
  localparam logic [OP_W-1:0] OP_PACKUW = 5'd7;
  localparam logic [OP_W-1:0] OP_MIN    = 5'd8;
  localparam logic [OP_W-1:0] OP_MAX    = 5'd9;
  localparam logic [OP_W-1:0] OP_MINU   = 5'd10;
  localparam logic [OP_W-1:0] OP_MAXU   = 5'd11;
  localparam logic [OP_W-1:0] OP_SEXTB  = 5'd12;
  localparam logic [OP_W-1:0] OP_SEXTH  = 5'd13;
  localparam logic [OP_W-1:0] OP_BSET   = 5'd14;
  localparam logic [OP_W-1:0] OP_BCLR   = 5'd15;
  localparam logic [OP_W-1:0] OP_BINV   = 5'd16;
  localparam logic [OP_W-1:0] OP_BEXT   = 5'd17;

  typedef enum logic [2:0] {
    UNIT_LOGIC,
    UNIT_PACK,
    UNIT_CMP,
    UNIT_SEXT,
    UNIT_BIT,
    UNIT_NONE
  } unit_e;

  // Pack sub-selects
  localparam logic [2:0] PK_HALF_LO = 3'd0;
  localparam logic [2:0] PK_HALF_HI = 3'd1;
  localparam logic [2:0] PK_BYTE    = 3'd2;
  localparam logic [2:0] PK_WORD_LO = 3'd3;
  localparam logic [2:0] PK_WORD_HI = 3'd4;

  typedef struct packed {
    unit_e      unit;
    logic [2:0] sub;
    logic       illegal;
  } aluCtrl_t;
endpackage

// File: rtl/bmpa_ctrl.sv
module bmpa_ctrl
  import bmpa_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [OP_W-1:0] opSel,
  output aluCtrl_t        ctrl
);
  localparam bit HAS_WORD = (XLEN >= 64);

  always_comb begin
    ctrl.unit    = UNIT_NONE;
    ctrl.sub     = 3'd0;
    ctrl.illegal = 1'b0;
    unique case (opSel)
      OP_ANDN:   begin ctrl.unit = UNIT_LOGIC; ctrl.sub = 3'd0; end
      OP_ORN:    begin ctrl.unit = UNIT_LOGIC; ctrl.sub = 3'd1; end
      OP_XNOR:   begin ctrl.unit = UNIT_LOGIC; ctrl.sub = 3'd2; end
      OP_PACK:   begin ctrl.unit = UNIT_PACK;  ctrl.sub = PK_HALF_LO; end
      OP_PACKU:  begin ctrl.unit = UNIT_PACK;  ctrl.sub = PK_HALF_HI; end
      OP_PACKH:  begin ctrl.unit = UNIT_PACK;  ctrl.sub = PK_BYTE; end
      OP_PACKW: begin
        if (HAS_WORD) begin ctrl.unit = UNIT_PACK; ctrl.sub = PK_WORD_LO; end
        else ctrl.illegal = 1'b1;
      end
      OP_PACKUW: begin
        if (HAS_WORD) begin ctrl.unit = UNIT_PACK; ctrl.sub = PK_WORD_HI; end
        else ctrl.illegal = 1'b1;
      end
      // cmp sub: bit0 = unsigned, bit1 = max
      OP_MIN:    begin ctrl.unit = UNIT_CMP;  ctrl.sub = 3'b000; end
      OP_MAX:    begin ctrl.unit = UNIT_CMP;  ctrl.sub = 3'b010; end
      OP_MINU:   begin ctrl.unit = UNIT_CMP;  ctrl.sub = 3'b001; end
      OP_MAXU:   begin ctrl.unit = UNIT_CMP;  ctrl.sub = 3'b011; end
      OP_SEXTB:  begin ctrl.unit = UNIT_SEXT; ctrl.sub = 3'd0; end
      OP_SEXTH:  begin ctrl.unit = UNIT_SEXT; ctrl.sub = 3'd1; end
      OP_BSET:   begin ctrl.unit = UNIT_BIT;  ctrl.sub = 3'd0; end
      OP_BCLR:   begin ctrl.unit = UNIT_BIT;  ctrl.sub = 3'd1; end
      OP_BINV:   begin ctrl.unit = UNIT_BIT;  ctrl.sub = 3'd2; end
      OP_BEXT:   begin ctrl.unit = UNIT_BIT;  ctrl.sub = 3'd3; end
      default:   ctrl.illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/bmpa_datapath.sv
module bmpa_datapath
  import bmpa_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IMM_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  aluCtrl_t         ctrl,
  input  logic             useImm,
  input  logic [IMM_W-1:0] imm,
  input  logic [XLEN-1:0]  rs1,
  input  logic [XLEN-1:0]  rs2,
  output logic             outValid,
  output logic [XLEN-1:0]  result,
  output logic             illegalOp
);
  localparam int HALF  = XLEN / 2;
  localparam int IDX_W = $clog2(XLEN);

  logic [IDX_W-1:0] bitIdx;
  logic [XLEN-1:0]  logicRes, packRes, cmpRes, sextRes, bitRes, nextRes;
  logic [XLEN-1:0]  packHalfLo, packHalfHi, packByte, packWordLo, packWordHi;
  logic [XLEN-1:0]  oneHot;
  logic             lessThan;

  // Index truncated to log2(XLEN) bits
  assign bitIdx = useImm ? imm[IDX_W-1:0] : rs2[IDX_W-1:0];
  assign oneHot = {{(XLEN-1){1'b0}}, 1'b1} << bitIdx;

  always_comb begin
    unique case (ctrl.sub[1:0])
      2'd0:    logicRes = rs1 & ~rs2;
      2'd1:    logicRes = rs1 | ~rs2;
      default: logicRes = ~(rs1 ^ rs2);
    endcase
  end

  assign packHalfLo = {rs2[HALF-1:0], rs1[HALF-1:0]};
  assign packHalfHi = {rs2[XLEN-1:HALF], rs1[XLEN-1:HALF]};
  assign packByte   = {{(XLEN-16){1'b0}}, rs2[7:0], rs1[7:0]};

  generate
    if (XLEN >= 64) begin : gWordPack
      logic [31:0] wordLo, wordHi;
      assign wordLo     = {rs2[15:0], rs1[15:0]};
      assign wordHi     = {rs2[31:16], rs1[31:16]};
      assign packWordLo = {{(XLEN-32){wordLo[31]}}, wordLo};
      assign packWordHi = {{(XLEN-32){wordHi[31]}}, wordHi};
    end else begin : gNoWordPack
      assign packWordLo = '0;
      assign packWordHi = '0;
    end
  endgenerate

  always_comb begin
    unique case (ctrl.sub)
      PK_HALF_LO: packRes = packHalfLo;
      PK_HALF_HI: packRes = packHalfHi;
      PK_BYTE:    packRes = packByte;
      PK_WORD_LO: packRes = packWordLo;
      default:    packRes = packWordHi;
    endcase
  end

  assign lessThan = ctrl.sub[0] ? (rs1 < rs2) : ($signed(rs1) < $signed(rs2));
  assign cmpRes   = (ctrl.sub[1] ^ lessThan) ? rs1 : rs2;

  assign sextRes = ctrl.sub[0] ? {{(XLEN-16){rs1[15]}}, rs1[15:0]}
                               : {{(XLEN-8){rs1[7]}}, rs1[7:0]};

  always_comb begin
    unique case (ctrl.sub[1:0])
      2'd0:    bitRes = rs1 | oneHot;
      2'd1:    bitRes = rs1 & ~oneHot;
      2'd2:    bitRes = rs1 ^ oneHot;
      default: bitRes = {{(XLEN-1){1'b0}}, rs1[bitIdx]};
    endcase
  end

  always_comb begin
    unique case (ctrl.unit)
      UNIT_LOGIC: nextRes = logicRes;
      UNIT_PACK:  nextRes = packRes;
      UNIT_CMP:   nextRes = cmpRes;
      UNIT_SEXT:  nextRes = sextRes;
      UNIT_BIT:   nextRes = bitRes;
      default:    nextRes = '0;
    endcase
    if (ctrl.illegal) nextRes = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      result    <= '0;
      illegalOp <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        result    <= nextRes;
        illegalOp <= ctrl.illegal;
      end
    end
  end
endmodule

// File: rtl/bitmanip_pack_alu.sv
module bitmanip_pack_alu
  import bmpa_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IMM_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [4:0]       opSel,
  input  logic             useImm,
  input  logic [IMM_W-1:0] imm,
  input  logic [XLEN-1:0]  rs1,
  input  logic [XLEN-1:0]  rs2,
  output logic             outValid,
  output logic [XLEN-1:0]  result,
  output logic             illegalOp
);
  aluCtrl_t aluCtrl;

  bmpa_ctrl #(.XLEN(XLEN)) uCtrl (
    .opSel (opSel),
    .ctrl  (aluCtrl)
  );

  bmpa_datapath #(.XLEN(XLEN), .IMM_W(IMM_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .ctrl      (aluCtrl),
    .useImm    (useImm),
    .imm       (imm),
    .rs1       (rs1),
    .rs2       (rs2),
    .outValid  (outValid),
    .result    (result),
    .illegalOp (illegalOp)
  );
endmodule

// File: rtl/bmpa_checker.sv
module bmpa_checker
  import bmpa_pkg::*;
#(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rstN,
  input logic            inValid,
  input logic [4:0]      opSel,
  input logic [XLEN-1:0] rs1,
  input logic [XLEN-1:0] rs2,
  input logic            outValid,
  input logic [XLEN-1:0] result,
  input logic            illegalOp
);
  assert_issue_valid_R12: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(result)));

  assert_illegal_zero_R13: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && illegalOp) |-> (result == '0));

  assert_bext_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == OP_BEXT) |=> (result[XLEN-1:1] == '0));

  assert_binv_onebit_R9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == OP_BINV) |=> ($countones(result ^ $past(rs1)) == 1));

  assert_minmax_pick_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (opSel == OP_MIN || opSel == OP_MAX))
      |=> (result == $past(rs1) || result == $past(rs2)));

  assert_minmaxu_pick_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (opSel == OP_MINU || opSel == OP_MAXU))
      |=> (result == $past(rs1) || result == $past(rs2)));

  assert_packh_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == OP_PACKH) |=> (result[XLEN-1:16] == '0));

  assert_sextb_fill_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == OP_SEXTB)
      |=> (result[XLEN-1:7] == '0 || result[XLEN-1:7] == '1));
endmodule

bind bitmanip_pack_alu bmpa_checker #(.XLEN(XLEN)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .opSel     (opSel),
  .rs1       (rs1),
  .rs2       (rs2),
  .outValid  (outValid),
  .result    (result),
  .illegalOp (illegalOp)
);

// File: tb/sim_bitmanip_pack_alu.sv
`timescale 1ns/1ps
module sim_bitmanip_pack_alu;
  localparam int XLEN  = 64;
  localparam int IMM_W = 12;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             inValid = 1'b0;
  logic [4:0]       opSel = '0;
  logic             useImm = 1'b0;
  logic [IMM_W-1:0] imm = '0;
  logic [XLEN-1:0]  rs1 = '0;
  logic [XLEN-1:0]  rs2 = '0;
  logic             outValid;
  logic [XLEN-1:0]  result;
  logic             illegalOp;

  int testCount = 0;
  int failCount = 0;

  always #4 clk = ~clk;

  bitmanip_pack_alu #(.XLEN(XLEN), .IMM_W(IMM_W)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .useImm(useImm), .imm(imm), .rs1(rs1), .rs2(rs2),
    .outValid(outValid), .result(result), .illegalOp(illegalOp)
  );

  function automatic string reqOf(input logic [4:0] op);
    case (op)
      0, 1, 2: return "R1";
      3:       return "R2";
      4:       return "R3";
      5:       return "R4";
      6, 7:    return "R5";
      8, 9:    return "R6";
      10, 11:  return "R7";
      12, 13:  return "R8";
      14, 15, 16: return "R9";
      17:      return "R10";
      default: return "R13";
    endcase
  endfunction

  function automatic logic [63:0] model(input logic [4:0] op, input logic [63:0] a,
                                        input logic [63:0] b, input logic ui,
                                        input logic [11:0] im);
    int k;
    logic [31:0] w;
    k = ui ? int'(im[5:0]) : int'(b[5:0]);
    case (op)
      0:  return a & ~b;
      1:  return a | ~b;
      2:  return ~(a ^ b);
      3:  return {b[31:0], a[31:0]};
      4:  return {b[63:32], a[63:32]};
      5:  return {48'd0, b[7:0], a[7:0]};
      6:  begin w = {b[15:0], a[15:0]};  return {{32{w[31]}}, w}; end
      7:  begin w = {b[31:16], a[31:16]}; return {{32{w[31]}}, w}; end
      8:  return ($signed(a) < $signed(b)) ? a : b;
      9:  return ($signed(a) > $signed(b)) ? a : b;
      10: return (a < b) ? a : b;
      11: return (a > b) ? a : b;
      12: return {{56{a[7]}}, a[7:0]};
      13: return {{48{a[15]}}, a[15:0]};
      14: begin a[k] = 1'b1; return a; end
      15: begin a[k] = 1'b0; return a; end
      16: begin a[k] = ~a[k]; return a; end
      17: return {63'd0, a[k]};
      default: return 64'd0;
    endcase
  endfunction

  function automatic logic [63:0] pickVal();
    case ($urandom_range(0, 7))
      0: return 64'd0;
      1: return '1;
      2: return 64'h8000_0000_0000_0000;
      3: return 64'h7FFF_FFFF_FFFF_FFFF;
      4: return 64'd1 << $urandom_range(0, 63);
      default: return {$urandom, $urandom};
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic runOp(input logic [4:0] op, input logic [63:0] a, input logic [63:0] b,
                       input logic ui, input logic [11:0] im);
    logic [63:0] exp;
    exp = model(op, a, b, ui, im);
    @(negedge clk);
    inValid = 1'b1; opSel = op; rs1 = a; rs2 = b; useImm = ui; imm = im;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    check(reqOf(op), $sformatf("op %0d result", op), result, exp);
    check("R12", "outValid after issue", {63'd0, outValid}, 64'd1);
    check(reqOf(op), "illegalOp", {63'd0, illegalOp}, {63'd0, (op > 5'd17)});
  endtask

  initial begin
    #(8 * 200000);
    failCount++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R14", "reset result", result, 64'd0);
    check("R14", "reset outValid", {63'd0, outValid}, 64'd0);
    check("R14", "reset illegalOp", {63'd0, illegalOp}, 64'd0);
    rstN = 1'b1;

    // Directed corners
    runOp(5'd0, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 0, 0); // R1
    runOp(5'd2, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 0, 0); // R1
    runOp(5'd3, 64'hAAAA_BBBB_CCCC_DDDD, 64'h1111_2222_3333_4444, 0, 0); // R2
    runOp(5'd4, 64'hAAAA_BBBB_CCCC_DDDD, 64'h1111_2222_3333_4444, 0, 0); // R3
    runOp(5'd5, 64'hFFFF_FFFF_FFFF_FF5A, 64'hFFFF_FFFF_FFFF_FFA5, 0, 0); // R4
    runOp(5'd6, 64'h0000_0000_0000_1234, 64'h0000_0000_0000_8001, 0, 0); // R5 negative
    runOp(5'd7, 64'h0000_0000_5678_0000, 64'h0000_0000_7FFF_0000, 0, 0); // R5 positive
    runOp(5'd7, 64'h0000_0000_5678_0000, 64'h0000_0000_8000_0000, 0, 0); // R5 negative
    runOp(5'd8, 64'h8000_0000_0000_0000, 64'd1, 0, 0);                   // R6
    runOp(5'd9, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 0, 0);                   // R6
    runOp(5'd10, 64'h8000_0000_0000_0000, 64'd1, 0, 0);                  // R7
    runOp(5'd11, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 0, 0);                  // R7
    runOp(5'd8, 64'd77, 64'd77, 0, 0);                                   // R6 equal
    runOp(5'd12, 64'h0000_0000_0000_0080, 0, 0, 0);                      // R8
    runOp(5'd13, 64'hFFFF_FFFF_FFFF_7FFF, 0, 0, 0);                      // R8
    runOp(5'd14, 64'd0, 64'd63, 0, 0);                                   // R9 top bit
    runOp(5'd15, '1, 64'hFFC0, 0, 0);                                    // R9/R11 index 0
    runOp(5'd16, 64'd0, 64'd0, 1, 12'hFC5);                              // R11 imm truncation
    runOp(5'd17, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FF7F, 0, 0);// R10/R11
    runOp(5'd17, 64'h20, 64'd63, 1, 12'h045);                            // R11 imm wins
    runOp(5'd18, '1, '1, 0, 0);                                          // R13
    runOp(5'd31, '1, '1, 0, 0);                                          // R13

    // R12: idle cycle holds result, drops outValid
    runOp(5'd2, 64'h0123, 64'h4567, 0, 0);
    @(negedge clk);
    rs1 = '1; rs2 = 64'd5; opSel = 5'd14;
    @(posedge clk);
    @(negedge clk);
    check("R12", "idle hold result", result, model(5'd2, 64'h0123, 64'h4567, 0, 0));
    check("R12", "idle outValid", {63'd0, outValid}, 64'd0);

    // Random mix
    for (int i = 0; i < 1500; i++) begin
      logic [4:0] op;
      op = ($urandom_range(0, 9) == 0) ? 5'($urandom_range(18, 31))
                                       : 5'($urandom_range(0, 17));
      runOp(op, pickVal(), pickVal(), 1'($urandom_range(0, 1)), 12'($urandom));
    end

    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule